// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous burst SRAM. Its data bus is shared by reads and writes, and the two can follow each other on every clock with no idle cycle. Every command has one fixed bus slot. A command sampled on edge k owns the data bus during the cycle between edges k+1 and k+2. A read drives its word in that cycle. A write expects its data in that cycle and takes it on edge k+2. Because each slot is tied to its command, a read slot and a write slot never overlap and the bus never needs a turnaround gap.

Writes are committed late, so a read that follows a write to the same word would find stale data in the array. The model merges the pending write lanes straight from the bus into that read's output register. A two-bit wrapping burst counter lets a host issue one address and then continue for up to three more beats with the advance control. The burst keeps the operation that was last loaded. An active-low clock enable stalls the whole pipeline. The output enable gates the bus driver directly.

The data word is made of byte lanes of 9 bits each: 8 data bits and 1 parity bit. Lane i occupies bits [9i+8:9i], and its active-low write select is `bws_n[i]`.

Top module: `zt_sram`

## Requirements
- R1: While `rst_n` is low, and at the first sample after release, the block does not drive `dq`, and no command is in flight.
- R2: A read loaded on edge k (`cen_n`=0, `adv_ld`=0, chip selected, `we_n`=1) drives the stored word on `dq` after edge k+1, and holds it until the next enabled edge.
- R3: A write loaded on edge k (`we_n`=0) takes its data from `dq` on edge k+2. Only lanes whose `bws_n` bit was 0 at edge k change, and each such lane includes its parity bit.
- R4: A write with `bws_n` all ones leaves the addressed word unchanged.
- R5: A read loaded one edge after a write to the same address returns the pending write lanes, merged with the array contents for the lanes that are not written. It needs no idle cycle.
- R6: With `adv_ld`=1 the chip selects and `we_n` are ignored, the previous operation continues, and the address increments in its two low bits only. It wraps from 3 to 0 and leaves the upper bits unchanged.
- R7: With `adv_ld`=0 and the chip not selected (selected means `ce1_n`=0, `ce2`=1, `ce3_n`=0), no operation is loaded and `dq` stays undriven in the slot. Later `adv_ld`=1 cycles stay idle and write nothing.
- R8: `dq` is driven only in a read slot while `oe_n` is 0. A read with `oe_n`=1 is a dummy read that leaves the bus undriven.
- R9: An edge with `cen_n`=1 changes nothing: the loaded commands, the burst address, the output data, the bus drive and the memory all hold.
- R10: Reads and writes to different addresses alternated on consecutive edges each complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the command pipeline |
| cen_n | input | 1 | Active-low clock enable; high stalls everything |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new address and operation, 1 continues the burst |
| we_n | input | 1 | Active-low write enable, sampled on load |
| bws_n | input | LANES | Active-low per-lane write selects |
| oe_n | input | 1 | Active-low output enable, applied directly to the driver |
| addr | input | ADDR_W | Word address |
| dq | inout | LANES*LANE_W | Shared data bus with per-lane parity |

## Verification
The stimulus covers several access patterns:
- Single accesses with idle cycles between them. These separate array storage from pipelining.
- Partial and empty lane masks. These show that masking is done per lane and includes parity.
- A write followed at once by a read of the same word. This is the only pattern that exposes missing forwarding, and a partial mask there also shows per-lane merging.
- A four-beat burst that starts at low bits 2. This shows the wrap within the low two bits, and that the chip selects and write enable are ignored while advancing.
- Deselect, dummy-read and stall sequences. These show bus release, and that the pipeline holds with both read and write data in flight.
- A dense alternation of reads and writes. This shows that no turnaround cycle is needed.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv_ld,
  input  logic              we_n,
  input  logic [LANES-1:0]  bws_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [LANES*LANE_W-1:0] dq
);
  localparam int W     = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] OP_NONE = 2'd0;
  localparam logic [1:0] OP_RD   = 2'd1;
  localparam logic [1:0] OP_WR   = 2'd2;

  logic [W-1:0]      mem [DEPTH];
  logic [1:0]        s1_op, s2_op, n_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr, n_addr;
  logic [LANES-1:0]  s1_be, s2_be;
  logic [W-1:0]      rd_q, rd_next;
  logic              hit, drive;

  wire selected = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    n_op        = s1_op;
    n_addr      = s1_addr;
    n_addr[1:0] = s1_addr[1:0] + 2'd1;
    if (!adv_ld) begin
      n_op   = selected ? (we_n ? OP_RD : OP_WR) : OP_NONE;
      n_addr = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op <= OP_NONE;
      s2_op <= OP_NONE;
    end else if (!cen_n) begin
      s1_op <= n_op;
      s2_op <= s1_op;
    end
  end

  always_ff @(posedge clk) begin
    if (!cen_n) begin
      s1_addr <= n_addr;
      s1_be   <= ~bws_n;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  assign hit = (s2_op == OP_WR) && (s2_addr == s1_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_next[l*LANE_W +: LANE_W] = (hit && s2_be[l]) ? dq[l*LANE_W +: LANE_W]
                                                           : mem[s1_addr][l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!cen_n && s2_op == OP_WR) begin
      for (int l = 0; l < LANES; l++) begin
        if (s2_be[l]) mem[s2_addr][l*LANE_W +: LANE_W] <= dq[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!cen_n && s1_op == OP_RD) rd_q <= rd_next;
  end

  assign drive = (s2_op == OP_RD) && !oe_n;
  assign dq    = drive ? rd_q : {W{1'bz}};
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cen_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              adv_ld,
  input logic              oe_n,
  input logic [1:0]        s1_op,
  input logic [1:0]        s2_op,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              drive
);
  localparam logic [1:0] NONE = 2'd0;
  localparam logic [1:0] RD   = 2'd1;

  wire sel = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    if (!rst_n) assert_reset_idle_R1: assert (!drive);
  end

  assert_pipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cen_n |=> s2_op == $past(s1_op));

  assert_drive_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> s2_op == RD);

  assert_burst_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && s1_op != NONE) |=>
      (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1) &&
      (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])) &&
      (s1_op == $past(s1_op)));

  assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && !sel) |=> s1_op == NONE);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && s1_op == NONE) |=> s1_op == NONE);

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drive);

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> $stable(s1_op) && $stable(s2_op) && $stable(s1_addr));
endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .adv_ld(adv_ld), .oe_n(oe_n), .s1_op(s1_op), .s2_op(s2_op), .s1_addr(s1_addr),
  .drive(drive)
);

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int AW = 6, L = 4, LW = 9, W = L * LW;
  localparam logic [W-1:0] IDLE = '1;

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n = 0, cen_n = 1, ce1_n = 1, ce2 = 0, ce3_n = 1, adv_ld = 0, we_n = 1, oe_n = 0;
  logic [L-1:0]  bws_n = '1;
  logic [AW-1:0] addr = '0;
  logic          tb_en = 0;
  logic [W-1:0]  tb_dq = '0;
  wire  [W-1:0]  dq;

  assign dq = tb_en ? tb_dq : {W{1'bz}};
  for (genvar g = 0; g < W; g++) begin : g_pu
    pullup pu (dq[g]);
  end

  zt_sram #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adv_ld(adv_ld), .we_n(we_n), .bws_n(bws_n), .oe_n(oe_n), .addr(addr), .dq(dq));

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0]  ref_mem [64];
  int            p1_op = 0, p2_op = 0;
  logic [AW-1:0] p1_addr = '0, p2_addr = '0;
  logic [L-1:0]  p1_be = '0, p2_be = '0;
  logic [W-1:0]  p1_dat = '0, p2_dat = '0, p1_lit = '0, p2_lit = '0, exp_val = '0;
  bit            p1_has = 0, p2_has = 0;
  string         p1_tag = "R1", p2_tag = "R1";
  logic [W-1:0]  cmd_dat = '0, cmd_lit = '0;
  bit            cmd_has = 0;
  string         cmd_tag = "R1";

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && !cen_n) begin
      if (p2_op == 2)
        for (int l = 0; l < L; l++)
          if (p2_be[l]) ref_mem[p2_addr][l*LW +: LW] = dq[l*LW +: LW];
      p2_op = p1_op; p2_addr = p1_addr; p2_be = p1_be; p2_dat = p1_dat;
      p2_lit = p1_lit; p2_has = p1_has; p2_tag = p1_tag;
      if (!adv_ld) begin
        p1_op   = (!ce1_n && ce2 && !ce3_n) ? (we_n ? 1 : 2) : 0;
        p1_addr = addr;
      end else begin
        p1_addr[1:0] = p1_addr[1:0] + 2'd1;
      end
      p1_be = ~bws_n; p1_dat = cmd_dat; p1_lit = cmd_lit; p1_has = cmd_has; p1_tag = cmd_tag;
      if (p2_op == 1) exp_val = p2_has ? p2_lit : ref_mem[p2_addr];
    end
    #1;
    tb_en = (p2_op == 2);
    tb_dq = p2_dat;
    #3;
    if (rst_n) begin
      if (p2_op == 1 && !oe_n) chk(p2_tag, dq, exp_val);
      else if (p2_op != 2)     chk(p2_tag, dq, IDLE);
    end
  end

  task automatic drive_cmd(input bit ld, input bit sel, input bit wr, input logic [AW-1:0] a,
                           input logic [L-1:0] bw, input logic [W-1:0] d, input string tag,
                           input bit has, input logic [W-1:0] lit);
    @(negedge clk);
    cen_n = 0; adv_ld = !ld; ce1_n = !sel; ce2 = sel; ce3_n = !sel; we_n = !wr;
    addr = a; bws_n = bw; cmd_dat = d; cmd_tag = tag; cmd_has = has; cmd_lit = lit;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d, input logic [L-1:0] bw, input string tag);
    drive_cmd(1, 1, 1, a, bw, d, tag, 0, '0);
  endtask
  task automatic rd(input logic [AW-1:0] a, input logic [W-1:0] e, input string tag);
    drive_cmd(1, 1, 0, a, '1, '0, tag, 1, e);
  endtask
  task automatic rd_model(input logic [AW-1:0] a, input string tag);
    drive_cmd(1, 1, 0, a, '1, '0, tag, 0, '0);
  endtask
  task automatic nop(input logic [AW-1:0] a, input string tag);
    drive_cmd(1, 0, 0, a, '1, '0, tag, 0, '0);
  endtask
  task automatic adv(input logic [W-1:0] d, input bit has, input logic [W-1:0] lit, input string tag);
    drive_cmd(0, 0, 1, 6'h3f, '0, d, tag, has, lit);
  endtask
  task automatic stall(input int n);
    repeat (n) begin @(negedge clk); cen_n = 1; end
  endtask

  localparam logic [W-1:0] A0 = 36'h1_2345_6789, A1 = 36'h9_8765_4321;
  localparam logic [W-1:0] M02 = 36'h0_07FC_01FF, M03 = 36'hF_F800_01FF;

  task automatic t_reset;
    @(negedge clk); chk("R1", dq, IDLE);
    rst_n = 1;
    @(posedge clk); #4 chk("R1", dq, IDLE);
    nop(0, "R1"); nop(0, "R1");
  endtask

  task automatic t_basic;
    wr(5, A0, 4'b0000, "R3"); wr(12, A1, 4'b0000, "R3");
    nop(0, "R2"); nop(0, "R2");
    rd(5, A0, "R2"); rd(12, A1, "R2"); nop(0, "R2"); nop(0, "R2");
  endtask

  task automatic t_partial;
    logic [W-1:0] d = 36'hA_BCDE_F012;
    wr(5, d, 4'b1010, "R3"); nop(0, "R3"); nop(0, "R3");
    rd(5, (d & M02) | (A0 & ~M02), "R3"); nop(0, "R3"); nop(0, "R3");
  endtask

  task automatic t_nowrite;
    wr(12, 36'h0_5A5A_5A5A, 4'b1111, "R4"); nop(0, "R4"); nop(0, "R4");
    rd(12, A1, "R4"); nop(0, "R4"); nop(0, "R4");
  endtask

  task automatic t_forward;
    logic [W-1:0] x1 = 36'h3_1415_9265, x2 = 36'h2_7182_8182;
    wr(20, x1, 4'b0000, "R5"); rd(20, x1, "R5");
    wr(20, x2, 4'b0110, "R5"); rd(20, (x2 & M03) | (x1 & ~M03), "R5");
    nop(0, "R5"); nop(0, "R5");
  endtask

  task automatic t_burst;
    logic [W-1:0] d0 = 36'h0_1111_0000, d1 = 36'h0_2222_0001, d2 = 36'h0_3333_0002, d3 = 36'h0_4444_0003;
    wr(6, d0, 4'b0000, "R6"); adv(d1, 0, '0, "R6"); adv(d2, 0, '0, "R6"); adv(d3, 0, '0, "R6");
    nop(0, "R6"); nop(0, "R6");
    rd(6, d0, "R6"); adv('0, 1, d1, "R6"); adv('0, 1, d2, "R6"); adv('0, 1, d3, "R6");
    rd(4, d2, "R6"); rd(5, d3, "R6"); rd(7, d1, "R6"); nop(0, "R6"); nop(0, "R6");
  endtask

  task automatic t_deselect;
    nop(5, "R7"); adv(36'h0_DEAD_0BAD, 0, '0, "R7"); adv('0, 0, '0, "R7");
    nop(0, "R7"); nop(0, "R7");
    rd(6, 36'h0_1111_0000, "R7"); rd(7, 36'h0_2222_0001, "R7"); nop(0, "R7"); nop(0, "R7");
  endtask

  task automatic t_dummy;
    @(negedge clk); oe_n = 1;
    rd_model(12, "R8"); nop(0, "R8"); nop(0, "R8");
    @(negedge clk); oe_n = 0; cen_n = 0;
    rd(12, A1, "R8"); nop(0, "R8"); nop(0, "R8");
  endtask

  task automatic t_stall;
    logic [W-1:0] y = 36'h0_CAFE_0042;
    rd(12, A1, "R9"); nop(0, "R9");
    stall(3);
    nop(0, "R9");
    wr(30, y, 4'b0000, "R9"); rd(30, y, "R9");
    stall(3);
    nop(0, "R9"); nop(0, "R9");
    rd(30, y, "R9"); nop(0, "R9"); nop(0, "R9");
  endtask

  task automatic t_mix;
    logic [W-1:0] a = 36'h0_0F0F_1234, b = 36'h0_7070_5678, c = 36'h0_3C3C_9ABC;
    wr(40, a, 4'b0000, "R10"); rd(12, A1, "R10");
    wr(41, b, 4'b0000, "R10"); rd(40, a, "R10");
    wr(42, c, 4'b0000, "R10"); rd(41, b, "R10");
    rd(42, c, "R10"); wr(43, A0, 4'b0000, "R10"); rd(43, A0, "R10");
    nop(0, "R10"); nop(0, "R10");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_basic;
    t_partial;
    t_nowrite;
    t_forward;
    t_burst;
    t_deselect;
    t_dummy;
    t_stall;
    t_mix;
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule